// File: doc/BRIEF.md
# Vertical-Blank Status and Interrupt Request Controller

This block holds the vertical-blank status of a tile-based video controller and turns it into an active-low interrupt request for the host CPU. A raster counter outside the block sends two timing pulses. One marks the start of blanking and the other marks its end. The start pulse sets a blanking flag. The CPU clears that flag by reading the status register. The interrupt line is a live NAND of the flag and a software enable bit in the control register, not a latched event. Turning the enable off and back on while the flag is still set therefore gives the CPU a second falling edge within the same blanking period.

The block also owns the shared first/second write phase used by the two registers that take two writes each: the scroll register and the video-memory address register. Each write to either register flips the phase. A status read forces the phase back to "first", so software can resynchronise before a two-write sequence. The scroll and address values are brought out as ports for the rendering logic.

Two state machines do the work. The flag machine has the states FL_CLEAR and FL_SET. The transition FL_CLEAR→FL_SET is taken on a start pulse. The transition FL_SET→FL_CLEAR is taken on an end pulse or on a status read, unless a start pulse arrives in the same cycle. The phase machine has the states PH_FIRST and PH_SECOND. The transitions PH_FIRST→PH_SECOND and PH_SECOND→PH_FIRST are taken on a write to the scroll or address register. The transition to PH_FIRST is also taken on any status read.

Top module: `vbl_irq_ctrl`

## Requirements
- R1: After reset the flag is clear, the enable bit is 0, the phase is "first", `irq_n` is 1, and `vram_addr`, `scroll_x` and `scroll_y` are 0.
- R2: A `vbl_start` pulse sets the flag at the next clock edge. If `vbl_start` and `vbl_end` arrive together, the start pulse wins.
- R3: The flag is cleared only at the clock edge after a `vbl_end` pulse or after a read of the status register (offset 2). During that read, `rd_data` bit 7 shows the flag as it was before the clear, and bits 6..0 read 0.
- R4: A status read in the same cycle as `vbl_start` returns 0 on bit 7, and the flag stays set.
- R5: Bit 7 of a write to the control register (offset 0) is the interrupt enable. `irq_n` equals NOT(flag AND enable), so with the enable at 0 the line stays high.
- R6: Clearing and then setting the enable bit while the flag stays set produces a new falling edge on `irq_n` in the same blanking period.
- R7: A write to the address register (offset 6) in the "first" phase loads `vram_addr[15:8]`. In the "second" phase it loads `vram_addr[7:0]`.
- R8: A write to the scroll register (offset 5) in the "first" phase loads `scroll_x`. In the "second" phase it loads `scroll_y`.
- R9: Every write to offset 5 or 6 flips the shared phase. A status read returns the phase to "first", so the next such write counts as a first write.
- R10: Reads of any offset other than 2 return 0 and change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 8 | Write data |
| reg_rd | input | 1 | Read strobe, one cycle per access |
| reg_wr | input | 1 | Write strobe, one cycle per access |
| vbl_start | input | 1 | Start-of-blanking pulse |
| vbl_end | input | 1 | End-of-blanking pulse |
| rd_data | output | 8 | Combinational read data |
| irq_n | output | 1 | Active-low interrupt request |
| vram_addr | output | 16 | Video-memory address register |
| scroll_x | output | 8 | First scroll value |
| scroll_y | output | 8 | Second scroll value |

## Verification
A wrong flag state shows up on `irq_n` in the same cycle whenever the enable is 1, and shows up on `rd_data` bit 7 at the next status read. A wrong phase stays hidden until the next write to offset 5 or 6. That write then lands in the wrong half of `vram_addr` or in the wrong scroll value, which is visible one cycle later. The bench therefore runs a reference model with the outputs compared every cycle. It mixes long random streams of register accesses and timing pulses with directed cases for enable toggling, reads coinciding with the start pulse, and status reads placed between the two halves of a two-write sequence.

// File: rtl/vbl_pkg.sv
package vbl_pkg;
    parameter int unsigned REG_AW = 3;
    parameter int unsigned DW     = 8;

    localparam logic [REG_AW-1:0] OFS_CTRL   = 3'd0;
    localparam logic [REG_AW-1:0] OFS_STATUS = 3'd2;
    localparam logic [REG_AW-1:0] OFS_SCROLL = 3'd5;
    localparam logic [REG_AW-1:0] OFS_ADDR   = 3'd6;

    typedef enum logic {
        FL_CLEAR = 1'b0,
        FL_SET   = 1'b1
    } flag_state_e;

    typedef enum logic {
        PH_FIRST  = 1'b0,
        PH_SECOND = 1'b1
    } phase_state_e;
endpackage

// File: rtl/vbl_flag_fsm.sv
module vbl_flag_fsm
    import vbl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_pulse,
    input  logic end_pulse,
    input  logic status_rd,
    output logic flag,
    output logic flag_seen
);
    flag_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= FL_CLEAR;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FL_CLEAR: if (set_pulse) state_d = FL_SET;
            FL_SET: begin
                if (!set_pulse && (end_pulse || status_rd)) state_d = FL_CLEAR;
            end
            default: state_d = FL_CLEAR;
        endcase
    end

    // Outputs: the flag, and the value a status read observes this cycle
    always_comb begin
        flag      = (state_q == FL_SET);
        flag_seen = flag && !set_pulse;
    end

    assert_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        set_pulse |=> flag);
    assert_end_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (end_pulse && !set_pulse) |=> !flag);
    assert_rd_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (status_rd && !set_pulse) |=> !flag);
    assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !end_pulse && !status_rd) |=> flag);
    assert_race_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (status_rd && set_pulse) |-> !flag_seen);
endmodule

// File: rtl/vbl_two_write_fsm.sv
module vbl_two_write_fsm
    import vbl_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           phase_clr,
    input  logic           wr_scroll,
    input  logic           wr_addr,
    input  logic [W-1:0]   wdata,
    output logic [2*W-1:0] vram_addr,
    output logic [W-1:0]   scroll_x,
    output logic [W-1:0]   scroll_y
);
    phase_state_e ph_q, ph_d;
    logic         any_wr;

    always_comb any_wr = wr_scroll || wr_addr;

    always_ff @(posedge clk) begin
        if (!rst_n) ph_q <= PH_FIRST;
        else        ph_q <= ph_d;
    end

    always_comb begin
        ph_d = ph_q;
        if (phase_clr) begin
            ph_d = PH_FIRST;
        end else begin
            unique case (ph_q)
                PH_FIRST:  if (any_wr) ph_d = PH_SECOND;
                PH_SECOND: if (any_wr) ph_d = PH_FIRST;
                default:   ph_d = PH_FIRST;
            endcase
        end
    end

    // Output registers, steered by the current phase
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vram_addr <= '0;
            scroll_x  <= '0;
            scroll_y  <= '0;
        end else if (!phase_clr) begin
            unique case (ph_q)
                PH_FIRST: begin
                    if (wr_addr)   vram_addr[2*W-1:W] <= wdata;
                    if (wr_scroll) scroll_x           <= wdata;
                end
                PH_SECOND: begin
                    if (wr_addr)   vram_addr[W-1:0] <= wdata;
                    if (wr_scroll) scroll_y         <= wdata;
                end
                default: ;
            endcase
        end
    end

    assert_phase_reset_R9: assert property (@(posedge clk) disable iff (!rst_n)
        phase_clr |=> (ph_q == PH_FIRST));
    assert_phase_flip_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (any_wr && !phase_clr) |=> (ph_q != $past(ph_q)));
    assert_addr_hi_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_addr && !phase_clr && ph_q == PH_FIRST) |=> (vram_addr[2*W-1:W] == $past(wdata)));
    assert_addr_lo_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_addr && !phase_clr && ph_q == PH_SECOND) |=> (vram_addr[W-1:0] == $past(wdata)));
    assert_scroll_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_scroll) |=> ($stable(scroll_x) && $stable(scroll_y)));
endmodule

// File: rtl/vbl_irq_ctrl.sv
module vbl_irq_ctrl
    import vbl_pkg::*;
#(
    parameter int unsigned EN_BIT   = 7,
    parameter int unsigned FLAG_BIT = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [DW-1:0]     reg_wdata,
    input  logic              reg_rd,
    input  logic              reg_wr,
    input  logic              vbl_start,
    input  logic              vbl_end,
    output logic [DW-1:0]     rd_data,
    output logic              irq_n,
    output logic [2*DW-1:0]   vram_addr,
    output logic [DW-1:0]     scroll_x,
    output logic [DW-1:0]     scroll_y
);
    logic status_rd, wr_ctrl, wr_scroll, wr_addr;
    logic flag, flag_seen, irq_en_q;

    always_comb begin
        status_rd = reg_rd && (reg_addr == OFS_STATUS);
        wr_ctrl   = reg_wr && (reg_addr == OFS_CTRL);
        wr_scroll = reg_wr && (reg_addr == OFS_SCROLL);
        wr_addr   = reg_wr && (reg_addr == OFS_ADDR);
    end

    vbl_flag_fsm u_flag (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_pulse (vbl_start),
        .end_pulse (vbl_end),
        .status_rd (status_rd),
        .flag      (flag),
        .flag_seen (flag_seen)
    );

    vbl_two_write_fsm #(.W(DW)) u_phase (
        .clk       (clk),
        .rst_n     (rst_n),
        .phase_clr (status_rd),
        .wr_scroll (wr_scroll),
        .wr_addr   (wr_addr),
        .wdata     (reg_wdata),
        .vram_addr (vram_addr),
        .scroll_x  (scroll_x),
        .scroll_y  (scroll_y)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)       irq_en_q <= 1'b0;
        else if (wr_ctrl) irq_en_q <= reg_wdata[EN_BIT];
    end

    always_comb begin
        irq_n   = !(flag && irq_en_q);
        rd_data = '0;
        if (status_rd) rd_data[FLAG_BIT] = flag_seen;
    end

    assert_irq_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_n) |-> flag);
    assert_irq_edge_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && reg_wdata[EN_BIT] && flag && !vbl_end && !status_rd) |=> !irq_n);
    assert_other_rd_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr != OFS_STATUS) |-> (rd_data == '0));
endmodule

// File: tb/vbl_irq_ctrl_bench.sv
module vbl_irq_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [7:0]  reg_wdata = '0;
    logic        reg_rd = 1'b0, reg_wr = 1'b0, vbl_start = 1'b0, vbl_end = 1'b0;
    logic [7:0]  rd_data, scroll_x, scroll_y;
    logic [15:0] vram_addr;
    logic        irq_n;

    always #10 clk = ~clk;

    vbl_irq_ctrl u_vbl_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rd(reg_rd), .reg_wr(reg_wr), .vbl_start(vbl_start), .vbl_end(vbl_end),
        .rd_data(rd_data), .irq_n(irq_n), .vram_addr(vram_addr),
        .scroll_x(scroll_x), .scroll_y(scroll_y)
    );

    typedef struct {
        logic [7:0]  rdata;
        logic        irq;
        logic [15:0] addr;
        logic [7:0]  sx;
        logic [7:0]  sy;
        string       tag;
    } exp_t;

    exp_t queue_q[$];
    int   n_vec = 0, n_bad = 0;
    bit   done = 1'b0;

    // reference model state
    bit          m_flag, m_en, m_ph;
    logic [15:0] m_addr;
    logic [7:0]  m_sx, m_sy;
    bit          prev_irq = 1'b1;
    int          falls = 0;

    task automatic op(input bit rd, input bit wr, input logic [2:0] a, input logic [7:0] d,
                      input bit st, input bit en, input string tag);
        exp_t e;
        @(negedge clk);
        reg_rd = rd; reg_wr = wr; reg_addr = a; reg_wdata = d;
        vbl_start = st; vbl_end = en;
        e.rdata = (rd && a == 3'd2) ? {m_flag && !st, 7'b0} : 8'h00;
        e.irq = !(m_flag && m_en);
        e.addr = m_addr; e.sx = m_sx; e.sy = m_sy; e.tag = tag;
        queue_q.push_back(e);
        if (st) m_flag = 1'b1;
        else if (en || (rd && a == 3'd2)) m_flag = 1'b0;
        if (rd && a == 3'd2) m_ph = 1'b0;
        if (wr && a == 3'd0) m_en = d[7];
        if (wr && a == 3'd5) begin
            if (!m_ph) m_sx = d; else m_sy = d;
            m_ph = !m_ph;
        end
        if (wr && a == 3'd6) begin
            if (!m_ph) m_addr[15:8] = d; else m_addr[7:0] = d;
            m_ph = !m_ph;
        end
    endtask

    task automatic idle(input string tag);
        op(1'b0, 1'b0, 3'd0, 8'h00, 1'b0, 1'b0, tag);
    endtask

    // monitor: compare a quarter period before the rising edge
    initial begin
        forever begin
            @(negedge clk);
            #5;
            if (queue_q.size() > 0) begin
                exp_t e;
                e = queue_q.pop_front();
                n_vec++;
                if (rd_data !== e.rdata || irq_n !== e.irq || vram_addr !== e.addr ||
                    scroll_x !== e.sx || scroll_y !== e.sy) begin
                    n_bad++;
                    $display("FAIL %s: got rd=%h irq=%b addr=%h sx=%h sy=%h exp rd=%h irq=%b addr=%h sx=%h sy=%h",
                             e.tag, rd_data, irq_n, vram_addr, scroll_x, scroll_y,
                             e.rdata, e.irq, e.addr, e.sx, e.sy);
                end
                if (prev_irq && !irq_n) falls++;
                prev_irq = irq_n;
            end
        end
    end

    initial begin
        #4000000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got hung run, exp completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        int f0;
        m_flag = 0; m_en = 0; m_ph = 0; m_addr = '0; m_sx = '0; m_sy = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle("R1 reset state");
        op(1'b1, 1'b0, 3'd2, 8'h00, 1'b0, 1'b0, "R1 flag clear after reset");
        // R2 set, R3 read clears and returns old value
        op(1'b0, 1'b0, 3'd0, 8'h00, 1'b1, 1'b0, "R2 start pulse");
        op(1'b1, 1'b0, 3'd2, 8'h00, 1'b0, 1'b0, "R3 read shows set flag");
        op(1'b1, 1'b0, 3'd2, 8'h00, 1'b0, 1'b0, "R3 read after clear");
        // R3 end pulse clears
        op(1'b0, 1'b0, 3'd0, 8'h00, 1'b1, 1'b0, "R2 start pulse");
        op(1'b0, 1'b0, 3'd0, 8'h00, 1'b0, 1'b1, "R3 end pulse");
        op(1'b1, 1'b0, 3'd2, 8'h00, 1'b0, 1'b0, "R3 end cleared flag");
        // R2 start wins over end
        op(1'b0, 1'b0, 3'd0, 8'h00, 1'b1, 1'b1, "R2 start and end together");
        op(1'b1, 1'b0, 3'd2, 8'h00, 1'b0, 1'b0, "R2 start won");
        // R4 race of read and start
        op(1'b1, 1'b0, 3'd2, 8'h00, 1'b1, 1'b0, "R4 read with start returns 0");
        op(1'b1, 1'b0, 3'd2, 8'h00, 1'b0, 1'b0, "R4 flag left set");
        // R5 enable gating
        op(1'b0, 1'b0, 3'd0, 8'h00, 1'b1, 1'b0, "R5 flag set, enable 0");
        idle("R5 irq_n high with enable 0");
        op(1'b0, 1'b1, 3'd0, 8'h7F, 1'b0, 1'b0, "R5 low bits do not enable");
        idle("R5 still high");
        // R6 re-enable gives a second falling edge
        f0 = falls;
        op(1'b0, 1'b1, 3'd0, 8'h80, 1'b0, 1'b0, "R6 enable");
        idle("R6 irq active");
        op(1'b0, 1'b1, 3'd0, 8'h00, 1'b0, 1'b0, "R6 disable");
        idle("R6 irq released");
        op(1'b0, 1'b1, 3'd0, 8'h80, 1'b0, 1'b0, "R6 re-enable");
        idle("R6 irq active again");
        idle("R6 settle");
        if (falls - f0 != 2) begin
            n_bad++;
            $display("FAIL R6: got %0d falling edges exp 2", falls - f0);
        end
        // R10 other reads are harmless
        op(1'b1, 1'b0, 3'd0, 8'h00, 1'b0, 1'b0, "R10 read ctrl offset");
        op(1'b1, 1'b0, 3'd6, 8'h00, 1'b0, 1'b0, "R10 read addr offset");
        idle("R10 irq still active");
        op(1'b1, 1'b0, 3'd2, 8'h00, 1'b0, 1'b0, "R3 read clears, irq released");
        idle("R5 irq released after read");
        // R7 address two writes
        op(1'b0, 1'b1, 3'd6, 8'h3F, 1'b0, 1'b0, "R7 addr high");
        op(1'b0, 1'b1, 3'd6, 8'h10, 1'b0, 1'b0, "R7 addr low");
        idle("R7 addr value");
        // R8 scroll two writes
        op(1'b0, 1'b1, 3'd5, 8'hA5, 1'b0, 1'b0, "R8 scroll x");
        op(1'b0, 1'b1, 3'd5, 8'h5A, 1'b0, 1'b0, "R8 scroll y");
        idle("R8 scroll values");
        // R9 shared phase and reset by status read
        op(1'b0, 1'b1, 3'd5, 8'h11, 1'b0, 1'b0, "R9 scroll first");
        op(1'b0, 1'b1, 3'd6, 8'h22, 1'b0, 1'b0, "R9 addr takes second phase");
        op(1'b0, 1'b1, 3'd6, 8'h33, 1'b0, 1'b0, "R9 addr first");
        op(1'b1, 1'b0, 3'd2, 8'h00, 1'b0, 1'b0, "R9 status read resets phase");
        op(1'b0, 1'b1, 3'd6, 8'h44, 1'b0, 1'b0, "R9 addr first again");
        op(1'b1, 1'b0, 3'd5, 8'h00, 1'b0, 1'b0, "R10 scroll read keeps phase");
        op(1'b0, 1'b1, 3'd6, 8'h55, 1'b0, 1'b0, "R9 addr second");
        idle("R9 final addr");
        // random mix against the model
        for (int i = 0; i < 3000; i++) begin
            int k;
            logic [2:0] a;
            k = $urandom_range(0, 9);
            a = (k < 3) ? 3'd2 : (k < 5) ? 3'd6 : (k < 7) ? 3'd5 : 3'($urandom_range(0, 7));
            if (k % 2 == 0)
                op(1'b1, 1'b0, a, 8'h00, ($urandom_range(0, 15) == 0), ($urandom_range(0, 15) == 0), "R9 random read");
            else
                op(1'b0, 1'b1, a, 8'($urandom), ($urandom_range(0, 15) == 0), ($urandom_range(0, 15) == 0), "R9 random write");
        end
        idle("R9 drain");
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule